// File: doc/BRIEF.md
# Test-Port Security Status Register with Instruction Filter

This block is the test-access-port slice of a device that reports its security configuration over the boundary-scan port. It has a standard 16-state TAP controller clocked by TCK, a 10-bit instruction register, and three data registers: a 1-bit bypass stage, a 32-bit identification register, and a 21-bit security status chain. When the status instruction is active, Capture-DR loads the chain from live security flags that the rest of the chip drives into the block. The host reads the chain with a 21-bit data scan that shifts in zeros.

Before an instruction is updated, a policy filter checks it. A tamper-protected device comes out of power-up in secure mode, where only a short mandatory list of instructions is honoured until the unlock instruction is accepted. A separate flag rejects the whole key-instruction group. A rejected opcode becomes BYPASS, both on the instruction output that other chip logic decodes and in the choice of data register.

Top module: `jtsec_tap`

## Requirements
- R1: After TRST the instruction output is IDCODE (0x006), and a 32-bit DR scan returns the ID_CODE parameter, least-significant bit first.
- R2: Capture-IR loads 0x001 into the instruction shift register, so an IR scan shifts out 0x001, LSB first.
- R3: With opcode 0x013 active, a 21-bit DR scan returns the status captured at Capture-DR. Flag bits 0–4, 6, 11–15, 17 and 20 come from the sec_flags input at the same positions.
- R4: Status bits 5, 7–10, 16 and 19 always read 0, whatever sec_flags holds.
- R5: Status bit 18 reports the internal secure-mode latch and not sec_flags[18].
- R6: If sec_flags[4] (tamper) is set at the first TCK edge after reset, secure mode is entered. In secure mode every opcode outside {0x3FF, 0x006, 0x005, 0x013, 0x031} is replaced by BYPASS 0x3FF at Update-IR.
- R7: In secure mode the opcodes 0x3FF, 0x006, 0x005 and 0x013 are accepted unchanged.
- R8: Accepting unlock (0x031) at Update-IR clears secure mode. Later opcodes are then no longer filtered, and status bit 18 reads 0.
- R9: While sec_flags[17] is set, every opcode whose upper six bits equal 000001 (0x010–0x01F, which includes 0x013) is replaced by 0x3FF, even in secure mode.
- R10: Any accepted opcode other than 0x013 and 0x006 selects the bypass register, which captures 0 and delays TDI by one TCK.
- R11: Five TMS-high clocks reach Test-Logic-Reset, which sets the instruction to 0x006. This does not re-enter secure mode. Only TRST re-arms it.
- R12: tdo_en is high only in the TCK periods spent in Shift-IR or Shift-DR, and TDO changes on the falling edge of TCK.
- R13: A TRST pulse with tamper set puts the block back into secure mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling TCK |
| tdo_en | output | 1 | High while TDO carries shift data |
| sec_flags | input | 21 | Live security flags, mapped to status bit positions |
| instr | output | 10 | Accepted instruction, for decode elsewhere in the chip |

## Verification
Both filters act on the same Update-IR edge: the secure-mode list and the key-group block. Opcode 0x013 is on the secure-mode allow list and is also in the key group. The bench provokes the overlap by arming secure mode through tamper and then raising sec_flags[17] before the status opcode is scanned in. It judges the outcome by instr reading 0x3FF and by a DR scan showing the one-stage bypass delay. The unlock opcode is a second overlap case: it is judged against the secure state that is still active while the same edge clears it. The bench checks this through the next filtered opcode and through status bit 18.

// File: rtl/jtsec_pkg.sv
package jtsec_pkg;
  localparam int IR_W   = 10;
  localparam int STAT_W = 21;

  localparam logic [IR_W-1:0] OP_BYPASS = 10'h3FF;
  localparam logic [IR_W-1:0] OP_IDCODE = 10'h006;
  localparam logic [IR_W-1:0] OP_SAMPLE = 10'h005;
  localparam logic [IR_W-1:0] OP_KEYVER = 10'h013;
  localparam logic [IR_W-1:0] OP_UNLOCK = 10'h031;
  localparam logic [IR_W-1:0] IR_CAPVAL = 10'h001;
  localparam logic [5:0]      KEY_GROUP = 6'b000001;

  localparam int B_TAMPER = 4;
  localparam int B_KEYDIS = 17;
  localparam int B_SECURE = 18;

  // positions that carry a defined flag; all others read zero
  localparam int NCARE = 14;
  localparam int CARE_POS [NCARE] = '{0, 1, 2, 3, 4, 6, 11, 12, 13, 14, 15, 17, 18, 20};

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI, ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PA_DR, ST_EX2_DR,
    ST_UPD_DR, ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PA_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  function automatic logic [STAT_W-1:0] care_mask();
    logic [STAT_W-1:0] m;
    m = '0;
    for (int i = 0; i < NCARE; i++) m[CARE_POS[i]] = 1'b1;
    return m;
  endfunction

  function automatic logic is_mandatory(input logic [IR_W-1:0] op);
    return (op == OP_BYPASS) || (op == OP_IDCODE) || (op == OP_SAMPLE) ||
           (op == OP_KEYVER) || (op == OP_UNLOCK);
  endfunction

  function automatic logic is_key_op(input logic [IR_W-1:0] op);
    return op[IR_W-1:IR_W-6] == KEY_GROUP;
  endfunction
endpackage

// File: rtl/jtsec_tap_fsm.sv
module jtsec_tap_fsm
  import jtsec_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tms,
  output tap_state_e state
);
  tap_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_TLR:    nxt = tms ? ST_TLR    : ST_RTI;
      ST_RTI:    nxt = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PA_DR;
      ST_PA_DR:  nxt = tms ? ST_EX2_DR : ST_PA_DR;
      ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: nxt = tms ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PA_IR;
      ST_PA_IR:  nxt = tms ? ST_EX2_IR : ST_PA_IR;
      ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_RTI;
      default:   nxt = ST_TLR;
    endcase
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) state <= ST_TLR;
    else        state <= nxt;
  end
endmodule

// File: rtl/jtsec_ir.sv
module jtsec_ir
  import jtsec_pkg::*;
(
  input  logic            tck,
  input  logic            rst_n,
  input  tap_state_e      state,
  input  logic            tdi,
  input  logic            secure,
  input  logic            key_dis,
  output logic [IR_W-1:0] ir_sr,
  output logic [IR_W-1:0] instr,
  output logic            ir_tdo,
  output logic            unlock_acc
);
  logic [IR_W-1:0] filtered;
  logic            sr_en, in_en;
  logic [IR_W-1:0] sr_nxt, in_nxt;

  always_comb begin
    filtered = ir_sr;
    if (key_dis && is_key_op(ir_sr))          filtered = OP_BYPASS;
    else if (secure && !is_mandatory(ir_sr))  filtered = OP_BYPASS;
  end

  assign unlock_acc = (state == ST_UPD_IR) && (filtered == OP_UNLOCK);
  assign ir_tdo     = ir_sr[0];

  always_comb begin
    sr_en  = (state == ST_CAP_IR) || (state == ST_SH_IR);
    sr_nxt = (state == ST_CAP_IR) ? IR_CAPVAL : {tdi, ir_sr[IR_W-1:1]};
    in_en  = (state == ST_UPD_IR) || (state == ST_TLR);
    in_nxt = (state == ST_TLR) ? OP_IDCODE : filtered;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)     ir_sr <= IR_CAPVAL;
    else if (sr_en) ir_sr <= sr_nxt;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)     instr <= OP_IDCODE;
    else if (in_en) instr <= in_nxt;
  end
endmodule

// File: rtl/jtsec_dr.sv
module jtsec_dr
  import jtsec_pkg::*;
#(
  parameter logic [31:0] ID_CODE = 32'h0A51_C0DD
) (
  input  logic              tck,
  input  logic              rst_n,
  input  tap_state_e        state,
  input  logic              tdi,
  input  logic [IR_W-1:0]   instr,
  input  logic [STAT_W-1:0] status_in,
  output logic              dr_tdo
);
  localparam int ID_W = $bits(ID_CODE);

  typedef enum logic [1:0] {SEL_BYP, SEL_ID, SEL_STAT} dr_sel_e;

  dr_sel_e           sel;
  logic              cap, shf;
  logic              byp_q;
  logic [ID_W-1:0]   id_q;
  logic [STAT_W-1:0] st_q;

  always_comb begin
    sel = SEL_BYP;
    if (instr == OP_KEYVER)      sel = SEL_STAT;
    else if (instr == OP_IDCODE) sel = SEL_ID;
    cap = (state == ST_CAP_DR);
    shf = (state == ST_SH_DR);
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)                          byp_q <= 1'b0;
    else if (sel == SEL_BYP && (cap || shf)) byp_q <= cap ? 1'b0 : tdi;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)                         id_q <= '0;
    else if (sel == SEL_ID && (cap || shf)) id_q <= cap ? ID_CODE : {tdi, id_q[ID_W-1:1]};
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)                           st_q <= '0;
    else if (sel == SEL_STAT && (cap || shf)) st_q <= cap ? status_in : {tdi, st_q[STAT_W-1:1]};
  end

  always_comb begin
    unique case (sel)
      SEL_STAT: dr_tdo = st_q[0];
      SEL_ID:   dr_tdo = id_q[0];
      default:  dr_tdo = byp_q;
    endcase
  end
endmodule

// File: rtl/jtsec_tap.sv
module jtsec_tap
  import jtsec_pkg::*;
#(
  parameter logic [31:0] ID_CODE = 32'h0A51_C0DD
) (
  input  logic              tck,
  input  logic              trst_n,
  input  logic              tms,
  input  logic              tdi,
  output logic              tdo,
  output logic              tdo_en,
  input  logic [STAT_W-1:0] sec_flags,
  output logic [IR_W-1:0]   instr
);
  localparam logic [STAT_W-1:0] CARE = care_mask();

  logic [1:0]        rs_q;
  logic              rst_n_s;
  tap_state_e        tap_state;
  logic [IR_W-1:0]   ir_sr;
  logic              ir_tdo, dr_tdo, unlock_acc;
  logic              armed_q, secure_q;
  logic              key_dis;
  logic [STAT_W-1:0] status_cap;
  logic              shifting;

  // reset: asserted asynchronously, released after two TCK edges
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) rs_q <= 2'b00;
    else         rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_s = rs_q[1];

  assign key_dis = sec_flags[B_KEYDIS];

  // secure-mode latch: armed from tamper once after reset, cleared by unlock
  always_ff @(posedge tck or negedge rst_n_s) begin
    if (!rst_n_s) begin
      armed_q  <= 1'b0;
      secure_q <= 1'b1;
    end else if (!armed_q) begin
      armed_q  <= 1'b1;
      secure_q <= sec_flags[B_TAMPER];
    end else if (unlock_acc) begin
      secure_q <= 1'b0;
    end
  end

  always_comb begin
    status_cap           = sec_flags & CARE;
    status_cap[B_SECURE] = secure_q;
  end

  jtsec_tap_fsm u_fsm (
    .tck   (tck),
    .rst_n (rst_n_s),
    .tms   (tms),
    .state (tap_state)
  );

  jtsec_ir u_ir (
    .tck        (tck),
    .rst_n      (rst_n_s),
    .state      (tap_state),
    .tdi        (tdi),
    .secure     (secure_q),
    .key_dis    (key_dis),
    .ir_sr      (ir_sr),
    .instr      (instr),
    .ir_tdo     (ir_tdo),
    .unlock_acc (unlock_acc)
  );

  jtsec_dr #(.ID_CODE(ID_CODE)) u_dr (
    .tck       (tck),
    .rst_n     (rst_n_s),
    .state     (tap_state),
    .tdi       (tdi),
    .instr     (instr),
    .status_in (status_cap),
    .dr_tdo    (dr_tdo)
  );

  assign shifting = (tap_state == ST_SH_IR) || (tap_state == ST_SH_DR);

  always_ff @(negedge tck or negedge rst_n_s) begin
    if (!rst_n_s) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo    <= shifting ? ((tap_state == ST_SH_IR) ? ir_tdo : dr_tdo) : 1'b0;
      tdo_en <= shifting;
    end
  end
endmodule

// File: rtl/jtsec_tap_chk.sv
module jtsec_tap_chk
  import jtsec_pkg::*;
(
  input logic            tck,
  input logic            rst_n,
  input tap_state_e      state,
  input logic [IR_W-1:0] ir_sr,
  input logic [IR_W-1:0] instr,
  input logic            secure,
  input logic            armed,
  input logic            key_dis,
  input logic            tdo_en
);
  AST_TDOEN_SHIFT: assert property (@(posedge tck) disable iff (!rst_n)
    tdo_en |-> (state == ST_SH_DR || state == ST_SH_IR)); // R12

  AST_SECURE_REJECT: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_UPD_IR && secure && !is_mandatory(ir_sr)) |=> (instr == OP_BYPASS)); // R6

  AST_KEYDIS_REJECT: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_UPD_IR && key_dis && is_key_op(ir_sr)) |=> (instr == OP_BYPASS)); // R9

  AST_UNLOCK_CLEAR: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_UPD_IR && armed && ir_sr == OP_UNLOCK) |=> !secure); // R8

  AST_TLR_IDCODE: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_TLR) |=> (instr == OP_IDCODE)); // R11

  AST_SECURE_STICKY: assert property (@(posedge tck) disable iff (!rst_n)
    (armed && !secure) |=> !secure); // R11
endmodule

bind jtsec_tap jtsec_tap_chk u_chk (
  .tck     (tck),
  .rst_n   (rst_n_s),
  .state   (tap_state),
  .ir_sr   (ir_sr),
  .instr   (instr),
  .secure  (secure_q),
  .armed   (armed_q),
  .key_dis (key_dis),
  .tdo_en  (tdo_en)
);

// File: tb/jtsec_tap_test.sv
`timescale 1ns/1ps
module jtsec_tap_test;
  localparam logic [31:0] IDV  = 32'h0A51_C0DD;
  localparam logic [20:0] CARE = 21'h16F85F;

  logic        tck = 1'b0;
  logic        trst_n, tms, tdi;
  logic        tdo, tdo_en;
  logic [20:0] flags;
  logic [9:0]  instr;

  int n_chk = 0, n_bad = 0, cyc = 0, en_err = 0;
  logic sec_m;
  bit   done = 0;

  jtsec_tap #(.ID_CODE(IDV)) uut (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
    .tdo(tdo), .tdo_en(tdo_en), .sec_flags(flags), .instr(instr)
  );

  always #2.5 tck = ~tck;

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  always @(posedge tck) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: act %0d cycles exp < 150000", cyc);
      finish_up();
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act %h exp %h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] model_op(input logic [9:0] op, input logic sec, input logic kd);
    if (kd && op[9:4] == 6'b000001) return 10'h3FF;
    if (sec && !(op == 10'h3FF || op == 10'h006 || op == 10'h005 || op == 10'h013 || op == 10'h031))
      return 10'h3FF;
    return op;
  endfunction

  function automatic logic [20:0] model_stat(input logic [20:0] f, input logic sec);
    logic [20:0] s;
    s = f & CARE;
    s[18] = sec;
    return s;
  endfunction

  task automatic tick(input logic m, input logic d, output logic o, output logic e);
    @(negedge tck); #1;
    o = tdo; e = tdo_en;
    tms = m; tdi = d;
    @(posedge tck); #1;
  endtask

  task automatic goto_reset();
    logic o, e;
    for (int i = 0; i < 5; i++) tick(1'b1, 1'b0, o, e);
    tick(1'b0, 1'b0, o, e);
  endtask

  task automatic scan_ir(input logic [9:0] op, output logic [9:0] cap);
    logic o, e;
    tick(1, 0, o, e); tick(1, 0, o, e); tick(0, 0, o, e); tick(0, 0, o, e);
    for (int i = 0; i < 10; i++) begin
      tick(i == 9, op[i], o, e);
      cap[i] = o;
      if (e !== 1'b1) en_err++;
    end
    tick(1, 0, o, e);
    if (e !== 1'b0) en_err++;
    tick(0, 0, o, e);
  endtask

  task automatic scan_dr(input int n, input logic [31:0] din, output logic [31:0] dout);
    logic o, e;
    dout = '0;
    tick(1, 0, o, e); tick(0, 0, o, e);
    if (e !== 1'b0) en_err++;
    tick(0, 0, o, e);
    for (int i = 0; i < n; i++) begin
      tick(i == n - 1, din[i], o, e);
      dout[i] = o;
      if (e !== 1'b1) en_err++;
    end
    tick(1, 0, o, e); tick(0, 0, o, e);
  endtask

  task automatic check_dr(input string req, input logic [9:0] eff, input logic [20:0] f, input logic sec);
    logic [31:0] d;
    logic [31:0] pat;
    if (eff == 10'h013) begin
      scan_dr(21, 32'h0, d);
      chk(req, d, {11'h0, model_stat(f, sec)});
    end else if (eff == 10'h006) begin
      scan_dr(32, 32'h0, d);
      chk(req, d, IDV);
    end else begin
      pat = {24'h0, 8'($urandom)};
      scan_dr(8, pat, d);
      chk({req, " R10 bypass"}, d, {24'h0, pat[6:0], 1'b0});
    end
  endtask

  task automatic do_reset(input logic [20:0] f);
    flags = f; tms = 1'b1; tdi = 1'b0; trst_n = 1'b0;
    repeat (3) @(posedge tck);
    @(negedge tck); trst_n = 1'b1;
    goto_reset();
    sec_m = f[4];
  endtask

  initial begin
    logic [9:0]  c;
    logic [31:0] d;
    logic [9:0]  op;
    logic [9:0]  list [8];
    void'($urandom(32'd4711));
    trst_n = 1'b0; tms = 1'b1; tdi = 1'b0; flags = '0;

    // power-up with tamper set
    do_reset(21'h000010);
    chk("R1 reset instr", {22'h0, instr}, 32'h006);
    chk("R12 tdo_en idle", {31'h0, tdo_en}, 32'h0);
    scan_dr(32, 32'h0, d);
    chk("R1 idcode", d, IDV);

    scan_ir(10'h020, c);
    chk("R2 ir capture", {22'h0, c}, 32'h001);
    chk("R6 secure rejects 0x020", {22'h0, instr}, 32'h3FF);
    check_dr("R6", 10'h3FF, flags, 1'b1);

    // status with every input bit high except key-disable
    flags = 21'h1DFFFF;
    scan_ir(10'h013, c);
    chk("R7 keyver in secure", {22'h0, instr}, 32'h013);
    scan_dr(21, 32'h0, d);
    chk("R3 status", d, {11'h0, model_stat(flags, 1'b1)});
    chk("R4 dont-care zero", d & ~{11'h0, CARE}, 32'h0);
    flags = 21'h000010;
    scan_dr(21, 32'h0, d);
    chk("R5 bit18 from latch", {31'h0, d[18]}, 32'h1);

    scan_ir(10'h005, c);
    chk("R7 sample in secure", {22'h0, instr}, 32'h005);
    scan_ir(10'h006, c);
    chk("R7 idcode in secure", {22'h0, instr}, 32'h006);

    // both filters on the same opcode: key group wins
    flags = 21'h020010;
    scan_ir(10'h013, c);
    chk("R9 keydis over secure", {22'h0, instr}, 32'h3FF);
    check_dr("R9", 10'h3FF, flags, 1'b1);
    scan_ir(10'h01A, c);
    chk("R9 key group 0x01A", {22'h0, instr}, 32'h3FF);

    // unlock
    scan_ir(10'h031, c);
    chk("R8 unlock accepted", {22'h0, instr}, 32'h031);
    sec_m = 1'b0;
    scan_ir(10'h020, c);
    chk("R8 filter off", {22'h0, instr}, 32'h020);
    check_dr("R10", 10'h020, flags, 1'b0);
    flags = 21'h040010;
    scan_ir(10'h013, c);
    scan_dr(21, 32'h0, d);
    chk("R8 R5 bit18 clear", {31'h0, d[18]}, 32'h0);

    // TMS reset does not re-arm
    scan_ir(10'h020, c);
    goto_reset();
    chk("R11 tlr idcode", {22'h0, instr}, 32'h006);
    scan_ir(10'h077, c);
    chk("R11 no re-arm", {22'h0, instr}, 32'h077);

    // random mix
    list[0] = 10'h3FF; list[1] = 10'h006; list[2] = 10'h005; list[3] = 10'h013;
    list[4] = 10'h031; list[5] = 10'h012; list[6] = 10'h020; list[7] = 10'h013;
    for (int it = 0; it < 60; it++) begin
      logic [9:0] eff;
      if (it == 30) do_reset(21'h000010 | 21'($urandom));
      flags = 21'($urandom);
      if (($urandom % 3) != 0) flags[17] = 1'b0;
      op = (($urandom % 4) == 0) ? 10'($urandom) : list[$urandom % 8];
      eff = model_op(op, sec_m, flags[17]);
      scan_ir(op, c);
      chk("R6 R7 R9 random ir", {22'h0, instr}, {22'h0, eff});
      if (eff == 10'h031) sec_m = 1'b0;
      check_dr("R3 random dr", eff, flags, sec_m);
    end

    // TRST re-arms
    do_reset(21'h000010);
    scan_ir(10'h020, c);
    chk("R13 trst re-arms", {22'h0, instr}, 32'h3FF);

    chk("R12 tdo_en in shift only", en_err, 0);
    finish_up();
  end
endmodule